// File: doc/BRIEF.md
# Keyboard Typematic Repeat Timer

This block generates auto-repeat for a single held key. A press event with a key code makes that key the typematic key and produces an immediate make event. The block then waits an initial delay, measured in 1 ms ticks. After the delay it emits a repeated make event once per repeat period, and it continues until the key is released, another key is pressed, or a control strobe clears the remembered key. Each event is a one-cycle `rep_valid` strobe, and `rep_code` carries the key code.

The delay and the period come from one packed rate/delay byte. The period is not a fixed count. It is computed as a mantissa, scaled by a power of two and by a constant, then rounded to whole milliseconds. The tick input is a single-cycle enable from a shared millisecond timebase. The control strobes match the usual keyboard commands. One enables scanning, one disables it, and one restores the power-on rate. Each of the three also forgets the held key.

The block has three FSM states:
- `ST_IDLE`: no key is held.
- `ST_DELAY`: the initial delay is counting.
- `ST_REPEAT`: the repeat period is counting.

The state transitions are:
- IDLE→DELAY on an accepted press.
- DELAY→DELAY on a press of a new key.
- DELAY→REPEAT when the delay expires.
- REPEAT→REPEAT when the period expires.
- REPEAT→DELAY on a new press.
- DELAY/REPEAT→IDLE on a matching release or on any control strobe.

Top module: `typematic_timer`

## Requirements
- R1: After reset, `rep_valid` is 0 and `rep_code` is 0. Scanning is enabled, and the rate/delay byte is 2Bh.
- R2: When scanning is enabled and no control strobe is active, a `key_press` produces `rep_valid`=1 with `rep_code` equal to the pressed code in the next cycle. That code becomes the typematic key.
- R3: The first repeat comes on the (D+1)×250th tick after the press cycle. D is bits 6..5 of the rate/delay byte. A tick in the press cycle itself is not counted.
- R4: After the first repeat, further repeats come every P ticks. P = ((8+A)×2^B×417+50)/100 with integer division. A is bits 2..0 and B is bits 4..3.
- R5: A `key_release` whose code equals the typematic key stops repeating and returns `rep_code` to 0. A release of any other code has no effect.
- R6: Pressing a key while another key is repeating replaces the typematic key. It emits an immediate event and restarts the delay phase.
- R7: `cfg_we` with bit 7 of `cfg_data` clear loads bits 6..0 as the new rate/delay byte. A write with bit 7 set is ignored. A new byte takes effect only at the next delay or period reload.
- R8: `load_dflt` restores the rate/delay byte to 2Bh, clears the typematic key and stops repeating. It does not change the enabled state, and it overrides a `cfg_we` in the same cycle.
- R9: `kb_disable` clears the typematic key and disables scanning, and presses are ignored until `kb_enable`. `kb_enable` also clears the typematic key. `kb_disable` wins over `kb_enable`.
- R10: Priority within one cycle: a control strobe beats a press, and a press beats a release.
- R11: Only ticks advance the counts. Without ticks, a held key produces no repeat events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle millisecond enable |
| key_press | input | 1 | Press event strobe |
| key_release | input | 1 | Release event strobe |
| key_code | input | KEY_W | Code of the pressed or released key |
| kb_enable | input | 1 | Enable scanning, forget the held key |
| kb_disable | input | 1 | Disable scanning, forget the held key |
| load_dflt | input | 1 | Restore the power-on rate, forget the held key |
| cfg_we | input | 1 | Rate/delay byte write strobe |
| cfg_data | input | 8 | Rate/delay byte |
| rep_valid | output | 1 | Make event strobe |
| rep_code | output | KEY_W | Typematic key code, 0 when none |

## Verification
The hardest situation to reach is a rate/delay write that lands in the middle of a running period. The old count must finish before the new values apply. The stimulus holds a key at the fastest setting with ticks every second cycle, waits until the repeat phase is established, and then writes the slowest setting. The behavioural model in the bench predicts whether the next event follows the old period or the new one. The same sequence also sends a byte with bit 7 set, to show that it is rejected without disturbing the running count.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_REPEAT = 2'd2
    } tm_state_e;

    localparam logic [6:0] RATE_POR = 7'h2B;
endpackage

// File: rtl/tmt_rate_decode.sv
module tmt_rate_decode #(
    parameter int CNT_W      = 10,
    parameter int DELAY_STEP = 250,
    parameter int PER_MUL    = 417,
    parameter int PER_DIV    = 100
) (
    input  logic [6:0]       rate,
    output logic [CNT_W-1:0] delay_ticks,
    output logic [CNT_W-1:0] period_ticks
);
    localparam int ROUND = PER_DIV / 2;

    logic [2:0]  mant;
    logic [1:0]  expo;
    logic [1:0]  dcode;
    logic [31:0] scaled;
    logic [31:0] per_full;
    logic [31:0] dly_full;

    always_comb begin
        mant     = rate[2:0];
        expo     = rate[4:3];
        dcode    = rate[6:5];
        // mantissa (8+A) shifted by exponent B, then scaled and rounded
        scaled   = (32'd8 + 32'(mant)) << expo;
        per_full = (scaled * 32'(PER_MUL) + 32'(ROUND)) / 32'(PER_DIV);
        dly_full = (32'(dcode) + 32'd1) * 32'(DELAY_STEP);
    end

    assign delay_ticks  = CNT_W'(dly_full);
    assign period_ticks = CNT_W'(per_full);
endmodule

// File: rtl/tmt_countdown.sv
module tmt_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = run && tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/typematic_timer.sv
module typematic_timer #(
    parameter int KEY_W      = 8,
    parameter int CNT_W      = 10,
    parameter int DELAY_STEP = 250,
    parameter int PER_MUL    = 417,
    parameter int PER_DIV    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             key_press,
    input  logic             key_release,
    input  logic [KEY_W-1:0] key_code,
    input  logic             kb_enable,
    input  logic             kb_disable,
    input  logic             load_dflt,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_data,
    output logic             rep_valid,
    output logic [KEY_W-1:0] rep_code
);
    import tmt_pkg::*;

    tm_state_e        state_q, state_d;
    logic             en_q;
    logic [6:0]       rate_q;
    logic [KEY_W-1:0] key_q;
    logic             valid_q;

    logic             ctl_clr;
    logic             press_ok;
    logic             rel_hit;
    logic             expire;
    logic             fire_rep;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] delay_ticks;
    logic [CNT_W-1:0] period_ticks;

    // event qualification, priority: control > press > release > expiry
    assign ctl_clr  = kb_disable | kb_enable | load_dflt;
    assign press_ok = !ctl_clr && key_press && en_q;
    assign rel_hit  = !ctl_clr && !press_ok && key_release &&
                      (state_q != ST_IDLE) && (key_code == key_q);
    assign fire_rep = !ctl_clr && !press_ok && !rel_hit && expire;
    assign cnt_load = press_ok | fire_rep;
    assign cnt_val  = press_ok ? delay_ticks : period_ticks;

    tmt_rate_decode #(
        .CNT_W      (CNT_W),
        .DELAY_STEP (DELAY_STEP),
        .PER_MUL    (PER_MUL),
        .PER_DIV    (PER_DIV)
    ) u_decode (
        .rate         (rate_q),
        .delay_ticks  (delay_ticks),
        .period_ticks (period_ticks)
    );

    tmt_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .run      (state_q != ST_IDLE),
        .tick     (tick_1ms),
        .expire   (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (press_ok) state_d = ST_DELAY;
            end
            ST_DELAY: begin
                if (ctl_clr)       state_d = ST_IDLE;
                else if (press_ok) state_d = ST_DELAY;
                else if (rel_hit)  state_d = ST_IDLE;
                else if (fire_rep) state_d = ST_REPEAT;
            end
            ST_REPEAT: begin
                if (ctl_clr)       state_d = ST_IDLE;
                else if (press_ok) state_d = ST_DELAY;
                else if (rel_hit)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and held configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            key_q   <= '0;
            en_q    <= 1'b1;
            rate_q  <= RATE_POR;
        end else begin
            valid_q <= press_ok | fire_rep;

            if (ctl_clr || rel_hit) key_q <= '0;
            else if (press_ok)      key_q <= key_code;

            if (kb_disable)     en_q <= 1'b0;
            else if (kb_enable) en_q <= 1'b1;

            if (load_dflt)                   rate_q <= RATE_POR;
            else if (cfg_we && !cfg_data[7]) rate_q <= cfg_data[6:0];
        end
    end

    assign rep_valid = valid_q;
    assign rep_code  = key_q;
endmodule

// File: rtl/typematic_timer_chk.sv
module typematic_timer_chk #(
    parameter int KEY_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_1ms,
    input logic               key_press,
    input logic               key_release,
    input logic [KEY_W-1:0]   key_code,
    input logic               kb_enable,
    input logic               kb_disable,
    input logic               load_dflt,
    input logic               cfg_we,
    input logic [7:0]         cfg_data,
    input logic               rep_valid,
    input logic [KEY_W-1:0]   rep_code,
    input tmt_pkg::tm_state_e state,
    input logic               enabled,
    input logic [6:0]         rate
);
    import tmt_pkg::*;

    logic ctl;
    assign ctl = kb_enable | kb_disable | load_dflt;

    p_valid_not_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> state != ST_IDLE);

    p_press_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_press && enabled && !ctl) |=> (rep_valid && rep_code == $past(key_code)));

    p_release_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_release && !key_press && !ctl && state != ST_IDLE && key_code == rep_code)
        |=> (!rep_valid && state == ST_IDLE && rep_code == '0));

    p_cfg_hi_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_data[7] && !load_dflt) |=> $stable(rate));

    p_ctl_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl |=> (state == ST_IDLE && !rep_valid && rep_code == '0));

    p_defaults_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt |=> rate == RATE_POR);

    p_disable_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kb_disable |=> !enabled);

    p_no_tick_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1ms && !key_press) |=> !rep_valid);
endmodule

bind typematic_timer typematic_timer_chk #(.KEY_W(KEY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .key_press   (key_press),
    .key_release (key_release),
    .key_code    (key_code),
    .kb_enable   (kb_enable),
    .kb_disable  (kb_disable),
    .load_dflt   (load_dflt),
    .cfg_we      (cfg_we),
    .cfg_data    (cfg_data),
    .rep_valid   (rep_valid),
    .rep_code    (rep_code),
    .state       (state_q),
    .enabled     (en_q),
    .rate        (rate_q)
);

// File: tb/typematic_timer_test.sv
module typematic_timer_test;
    localparam int CLK_P = 10;
    localparam int KW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1ms = 1'b0;
    logic          key_press = 1'b0;
    logic          key_release = 1'b0;
    logic [KW-1:0] key_code = '0;
    logic          kb_enable = 1'b0;
    logic          kb_disable = 1'b0;
    logic          load_dflt = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic          rep_valid;
    logic [KW-1:0] rep_code;

    int    vectors = 0;
    int    fails = 0;
    int    tick_div = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int          m_st, m_cnt, m_dly, m_per;
    logic [6:0]  m_rate, r_next;
    logic [KW-1:0] m_key;
    bit          m_en, m_valid;

    always #(CLK_P/2) clk = ~clk;

    typematic_timer uut (
        .clk (clk), .rst_n (rst_n), .tick_1ms (tick_1ms),
        .key_press (key_press), .key_release (key_release), .key_code (key_code),
        .kb_enable (kb_enable), .kb_disable (kb_disable), .load_dflt (load_dflt),
        .cfg_we (cfg_we), .cfg_data (cfg_data),
        .rep_valid (rep_valid), .rep_code (rep_code)
    );

    // behavioural model of the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_key = '0; m_rate = 7'h2B; m_en = 1; m_valid = 0;
        end else begin
            m_dly  = (int'(m_rate[6:5]) + 1) * 250;
            m_per  = ((8 + int'(m_rate[2:0])) * (1 << int'(m_rate[4:3])) * 417 + 50) / 100;
            r_next = load_dflt ? 7'h2B : ((cfg_we && !cfg_data[7]) ? cfg_data[6:0] : m_rate);
            m_valid = 0;
            if (kb_disable || kb_enable || load_dflt) begin
                if (kb_disable) m_en = 0;
                else if (kb_enable) m_en = 1;
                m_key = '0; m_st = 0;
            end else if (key_press && m_en) begin
                m_key = key_code; m_st = 1; m_cnt = m_dly; m_valid = 1;
            end else if (key_release && m_st != 0 && key_code == m_key) begin
                m_key = '0; m_st = 0;
            end else if (m_st != 0 && tick_1ms) begin
                if (m_cnt == 1) begin
                    m_valid = 1; m_st = 2; m_cnt = m_per;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_rate = r_next;
        end
    end

    // tick generation and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        tick_1ms <= (tick_div > 0) && (cyc % tick_div == 0);
        if (rst_n) begin
            vectors++;
            if (rep_valid !== m_valid || rep_code !== m_key) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%0b code=%h expected valid=%0b code=%h",
                         cur_req, cyc, rep_valid, rep_code, m_valid, m_key);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [KW-1:0] c);
        key_press = 1'b1; key_code = c;
        @(negedge clk);
        key_press = 1'b0;
    endtask

    task automatic release_key(input logic [KW-1:0] c);
        key_release = 1'b1; key_code = c;
        @(negedge clk);
        key_release = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] b);
        cfg_we = 1'b1; cfg_data = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        done = 1;
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        wait_cyc(3);
        vectors++;
        if (rep_valid !== 1'b0 || rep_code !== '0) begin
            fails++;
            $display("FAIL R1 reset: valid=%0b code=%h expected valid=0 code=00", rep_valid, rep_code);
        end
        rst_n = 1'b1;
        wait_cyc(2);

        // R2, R3, R4 at the power-on rate (delay 500, period 92), tick each cycle
        cur_req = "R2";
        tick_div = 1;
        press(8'h1C);
        cur_req = "R3";
        wait_cyc(505);
        cur_req = "R4";
        wait_cyc(300);

        // R11: ticks stopped, held key stays quiet
        cur_req = "R11";
        tick_div = 0;
        wait_cyc(300);
        tick_div = 1;

        // R5: release of another key ignored, matching release stops
        cur_req = "R5";
        release_key(8'h22);
        wait_cyc(150);
        release_key(8'h1C);
        wait_cyc(200);

        // R7: fastest rate, then slowest written mid-period, then a bit-7 byte
        cur_req = "R7";
        write_cfg(8'h00);
        tick_div = 2;
        press(8'h33);
        wait_cyc(500 + 66 * 2 + 20);
        write_cfg(8'h7F);
        write_cfg(8'h85);
        tick_div = 1;
        wait_cyc(1100);

        // R6: new key while repeating restarts the delay (1000 ticks)
        cur_req = "R6";
        press(8'h44);
        wait_cyc(1100);

        // R10: press and disable together, the press is lost
        cur_req = "R10";
        key_press = 1'b1; key_code = 8'h55; kb_disable = 1'b1;
        @(negedge clk);
        key_press = 1'b0; kb_disable = 1'b0;
        // R9: disabled, presses ignored; enable/disable together leaves disabled
        cur_req = "R9";
        press(8'h56);
        wait_cyc(20);
        kb_enable = 1'b1; kb_disable = 1'b1;
        @(negedge clk);
        kb_enable = 1'b0; kb_disable = 1'b0;
        press(8'h57);
        wait_cyc(20);
        kb_enable = 1'b1;
        @(negedge clk);
        kb_enable = 1'b0;
        press(8'h58);
        wait_cyc(30);
        kb_enable = 1'b1;
        @(negedge clk);
        kb_enable = 1'b0;
        wait_cyc(20);

        // R8: defaults beat a same-cycle write, rate back to 500/92
        cur_req = "R8";
        write_cfg(8'h00);
        press(8'h60);
        wait_cyc(40);
        load_dflt = 1'b1; cfg_we = 1'b1; cfg_data = 8'h00;
        @(negedge clk);
        load_dflt = 1'b0; cfg_we = 1'b0;
        press(8'h61);
        wait_cyc(700);

        // R10: press and matching release together, the press wins
        cur_req = "R10";
        key_press = 1'b1; key_release = 1'b1; key_code = 8'h61;
        @(negedge clk);
        key_press = 1'b0; key_release = 1'b0;
        wait_cyc(520);
        release_key(8'h61);
        wait_cyc(20);

        finish_run();
    end
endmodule